// File: doc/BRIEF.md
# Duplicated Pipelined S-box with Stall-on-Mismatch

This block computes the forward AES byte substitution as a five-stage pipeline. The arithmetic runs in a tower field: GF(2^2) is extended to GF(2^4) and then to GF(2^8), with one irreducible quadratic at each step. The input byte is mapped into the tower basis and then inverted there, in three stages. The result is mapped back to the standard basis, and the affine step is applied. With no faults present, a new byte enters on every clock.

Every stage computes its result twice. The two copies are compared before the stage register, and a mismatch raises that stage's error bit. While any error bit is high, every register in the pipeline holds its value and the upstream source is stalled. The faulty stage keeps evaluating the same operands until both copies agree, and then the pipe moves on. No byte is lost and no byte is repeated. A fault-injection port can flip one bit in one copy of one stage for a set number of cycles, so that the recovery can be exercised.

Top module: `sbox_dmr_pipe`

## Requirements
- R1: Each accepted byte x produces out_data equal to the AES forward S-box of x (multiplicative inverse in GF(2^8) modulo x^8+x^4+x^3+x+1, with 0 mapped to 0, followed by the affine step with constant 0x63).
- R2: With no disagreement, in_ready stays high, a byte can be accepted on every clock, and a byte accepted at clock edge E appears with out_valid high after edge E+4.
- R3: err_flags bit k (k = 0 is the input mapping stage, k = 4 is the output stage) is high exactly when both of these hold: stage k's copies disagree, and stage k's operand is valid. An injection into a stage whose operand is not valid raises no flag and leaves in_ready high.
- R4: While any err_flags bit is high, in_ready is low and out_valid is low on the following cycle.
- R5: A disagreement lasting N cycles on a stage with valid data stalls the pipe for exactly N cycles. Afterwards every accepted byte emerges exactly once, in acceptance order.
- R6: A clock edge with inj_start high loads inj_len, inj_stage, inj_copy (0 = first copy, 1 = second copy) and inj_bit. For the next inj_len cycles the selected bit of the selected copy of that stage is inverted.
- R7: While rst_n is low, out_valid and all err_flags are low, and any injection in progress is cancelled. After reset, in_ready is high and no stall remains.
- R8: out_data does not change on a cycle that follows a cycle with any err_flags bit high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert |
| in_valid | input | 1 | Input byte present |
| in_data | input | 8 | Byte to substitute |
| in_ready | output | 1 | Byte accepted on this edge when high together with in_valid |
| out_valid | output | 1 | One-cycle flag for a new result |
| out_data | output | 8 | Substituted byte |
| err_flags | output | 5 | Per-stage copy disagreement |
| inj_start | input | 1 | Load a new injection |
| inj_stage | input | 3 | Stage to disturb |
| inj_copy | input | 1 | Copy to disturb |
| inj_bit | input | 4 | Bit of the stage result to invert |
| inj_len | input | 8 | Injection length in cycles |

## Verification
Each of the ten stage and copy combinations is disturbed in the middle of a continuous byte stream. The length of each stall must match the injection length, including one long fault of 40 cycles. A design that dropped the held byte, let a corrupted value pass, or emitted a repeated result would produce a scoreboard mismatch or a leftover queue entry. An injection into an idle pipe must raise no flag, because a design that ignored the valid qualification would stall with no data present. A reset applied mid-fault must cancel the injection: if the injection survived the reset, the pipe would still stall after reset.

// File: rtl/sbox_tower_pkg.sv
package sbox_tower_pkg;
  localparam int NSTAGE = 5;
  localparam int SW     = 12;
  localparam int STG_W  = $clog2(NSTAGE);
  localparam int BIT_W  = $clog2(SW);
  localparam logic [1:0] PHI = 2'b10;

  typedef logic [7:0][7:0] cols_t;

  function automatic logic [1:0] g4_mul(input logic [1:0] a, input logic [1:0] b);
    logic hh;
    hh = a[1] & b[1];
    return {hh ^ (a[1] & b[0]) ^ (a[0] & b[1]), hh ^ (a[0] & b[0])};
  endfunction

  function automatic logic [1:0] g4_sq(input logic [1:0] a);
    return {a[1], a[1] ^ a[0]};
  endfunction

  function automatic logic [3:0] g16_mul(input logic [3:0] a, input logic [3:0] b);
    logic [1:0] hh;
    hh = g4_mul(a[3:2], b[3:2]);
    return {hh ^ g4_mul(a[3:2], b[1:0]) ^ g4_mul(a[1:0], b[3:2]),
            g4_mul(hh, PHI) ^ g4_mul(a[1:0], b[1:0])};
  endfunction

  function automatic logic [3:0] g16_inv(input logic [3:0] a);
    logic [1:0] dn, di;
    dn = g4_mul(g4_sq(a[3:2]), PHI) ^ g4_mul(a[3:2], a[1:0]) ^ g4_sq(a[1:0]);
    di = g4_sq(dn);
    return {g4_mul(a[3:2], di), g4_mul(a[3:2] ^ a[1:0], di)};
  endfunction

  // smallest element giving an irreducible z^2 + z + lambda over GF(16)
  function automatic logic [3:0] find_lambda();
    logic [3:0] res;
    logic found, hit;
    res = 4'h0;
    found = 1'b0;
    for (int l = 1; l < 16; l++) begin
      hit = 1'b0;
      for (int z = 0; z < 16; z++)
        if ((g16_mul(4'(z), 4'(z)) ^ 4'(z)) == 4'(l)) hit = 1'b1;
      if (!hit && !found) begin
        res = 4'(l);
        found = 1'b1;
      end
    end
    return res;
  endfunction

  localparam logic [3:0] LAMBDA = find_lambda();

  function automatic logic [7:0] g256_mul(input logic [7:0] a, input logic [7:0] b);
    logic [3:0] hh;
    hh = g16_mul(a[7:4], b[7:4]);
    return {hh ^ g16_mul(a[7:4], b[3:0]) ^ g16_mul(a[3:0], b[7:4]),
            g16_mul(hh, LAMBDA) ^ g16_mul(a[3:0], b[3:0])};
  endfunction

  // a tower element that satisfies the AES field polynomial
  function automatic logic [7:0] find_root();
    logic [7:0] pw [9];
    logic [7:0] res;
    logic found;
    res = 8'h00;
    found = 1'b0;
    for (int c = 2; c < 256; c++) begin
      pw[0] = 8'h01;
      for (int i = 1; i < 9; i++) pw[i] = g256_mul(pw[i-1], 8'(c));
      if ((pw[8] ^ pw[4] ^ pw[3] ^ pw[1] ^ pw[0]) == 8'h00 && !found) begin
        res = 8'(c);
        found = 1'b1;
      end
    end
    return res;
  endfunction

  localparam logic [7:0] BETA = find_root();

  function automatic logic [7:0] lin_map(input cols_t m, input logic [7:0] x);
    logic [7:0] acc;
    acc = 8'h00;
    for (int i = 0; i < 8; i++)
      if (x[i]) acc = acc ^ m[i];
    return acc;
  endfunction

  function automatic cols_t build_fwd();
    cols_t m;
    m[0] = 8'h01;
    for (int i = 1; i < 8; i++) m[i] = g256_mul(m[i-1], BETA);
    return m;
  endfunction

  localparam cols_t FWD = build_fwd();

  function automatic cols_t build_inv();
    cols_t m;
    m = '0;
    for (int j = 0; j < 8; j++)
      for (int e = 0; e < 256; e++)
        if (lin_map(FWD, 8'(e)) == (8'd1 << j)) m[j] = 8'(e);
    return m;
  endfunction

  localparam cols_t INV = build_inv();

  // stage operand layout: [11:8] high half, [7:4] low half, [3:0] norm
  function automatic logic [SW-1:0] stage_eval(input int stg, input logic [SW-1:0] d);
    logic [SW-1:0] r;
    logic [7:0] y;
    r = '0;
    y = 8'h00;
    case (stg)
      0: r[7:0] = lin_map(FWD, d[7:0]);
      1: r = {d[7:4], d[3:0],
              g16_mul(g16_mul(d[7:4], d[7:4]), LAMBDA) ^ g16_mul(d[7:4], d[3:0]) ^
              g16_mul(d[3:0], d[3:0])};
      2: r = {d[11:4], g16_inv(d[3:0])};
      3: r[7:0] = {g16_mul(d[11:8], d[3:0]), g16_mul(d[11:8] ^ d[7:4], d[3:0])};
      default: begin
        y = lin_map(INV, d[7:0]);
        r[7:0] = y ^ {y[6:0], y[7]} ^ {y[5:0], y[7:6]} ^ {y[4:0], y[7:5]} ^
                 {y[3:0], y[7:4]} ^ 8'h63;
      end
    endcase
    return r;
  endfunction
endpackage

// File: rtl/sbox_dmr_stage.sv
module sbox_dmr_stage
  import sbox_tower_pkg::*;
#(
  parameter int STG  = 0,
  parameter int OW   = SW,
  parameter bit LAST = 1'b0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          vin,
  input  logic [SW-1:0] din,
  input  logic [SW-1:0] mask_a,
  input  logic [SW-1:0] mask_b,
  output logic          vout,
  output logic [OW-1:0] dout,
  output logic          err
);
  logic [SW-1:0] cp [2];
  logic          v_d;
  logic [OW-1:0] d_d;

  for (genvar c = 0; c < 2; c++) begin : g_copy
    assign cp[c] = stage_eval(STG, din) ^ ((c == 0) ? mask_a : mask_b);
  end

  assign err = vin && (cp[0] != cp[1]);

  if (LAST) begin : g_pulse
    assign v_d = en & vin;
  end else begin : g_keep
    assign v_d = en ? vin : vout;
  end

  always_comb begin
    d_d = dout;
    if (en) d_d = cp[0][OW-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vout <= 1'b0;
    else        vout <= v_d;
  end

  always_ff @(posedge clk) begin
    dout <= d_d;
  end
endmodule

// File: rtl/sbox_fault_inject.sv
module sbox_fault_inject
  import sbox_tower_pkg::*;
#(
  parameter int LEN_W = 8
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        start,
  input  logic [STG_W-1:0]            stg,
  input  logic                        copy_sel,
  input  logic [BIT_W-1:0]            bit_sel,
  input  logic [LEN_W-1:0]            len,
  output logic [NSTAGE-1:0][SW-1:0]   mask_a,
  output logic [NSTAGE-1:0][SW-1:0]   mask_b
);
  logic [LEN_W-1:0] cnt_q, cnt_d;
  logic [STG_W-1:0] stg_q, stg_d;
  logic             copy_q, copy_d;
  logic [BIT_W-1:0] bit_q, bit_d;
  logic             active;

  always_comb begin
    cnt_d  = cnt_q;
    stg_d  = stg_q;
    copy_d = copy_q;
    bit_d  = bit_q;
    if (start) begin
      cnt_d  = len;
      stg_d  = stg;
      copy_d = copy_sel;
      bit_d  = bit_sel;
    end else if (cnt_q != '0) begin
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      stg_q  <= '0;
      copy_q <= 1'b0;
      bit_q  <= '0;
    end else begin
      cnt_q  <= cnt_d;
      stg_q  <= stg_d;
      copy_q <= copy_d;
      bit_q  <= bit_d;
    end
  end

  assign active = (cnt_q != '0);

  for (genvar s = 0; s < NSTAGE; s++) begin : g_mask
    logic hit;
    assign hit       = active && (stg_q == STG_W'(s));
    assign mask_a[s] = (hit && !copy_q) ? (SW'(1) << bit_q) : '0;
    assign mask_b[s] = (hit &&  copy_q) ? (SW'(1) << bit_q) : '0;
  end
endmodule

// File: rtl/sbox_hold_ctrl.sv
module sbox_hold_ctrl
  import sbox_tower_pkg::*;
(
  input  logic [NSTAGE-1:0] err,
  output logic              en,
  output logic              in_ready
);
  logic hold;
  assign hold     = |err;
  assign en       = ~hold;
  assign in_ready = ~hold;
endmodule

// File: rtl/sbox_dmr_pipe.sv
module sbox_dmr_pipe
  import sbox_tower_pkg::*;
#(
  parameter int LEN_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [7:0]        in_data,
  output logic              in_ready,
  output logic              out_valid,
  output logic [7:0]        out_data,
  output logic [NSTAGE-1:0] err_flags,
  input  logic              inj_start,
  input  logic [STG_W-1:0]  inj_stage,
  input  logic              inj_copy,
  input  logic [BIT_W-1:0]  inj_bit,
  input  logic [LEN_W-1:0]  inj_len
);
  logic [SW-1:0]             sd [NSTAGE];
  logic                      sv [NSTAGE];
  logic [NSTAGE-1:0][SW-1:0] mask_a;
  logic [NSTAGE-1:0][SW-1:0] mask_b;
  logic                      en;

  assign sd[0] = {{(SW-8){1'b0}}, in_data};
  assign sv[0] = in_valid;

  sbox_fault_inject #(.LEN_W(LEN_W)) u_inject (
    .clk(clk), .rst_n(rst_n), .start(inj_start), .stg(inj_stage),
    .copy_sel(inj_copy), .bit_sel(inj_bit), .len(inj_len),
    .mask_a(mask_a), .mask_b(mask_b)
  );

  sbox_hold_ctrl u_ctrl (.err(err_flags), .en(en), .in_ready(in_ready));

  for (genvar g = 0; g < NSTAGE; g++) begin : g_stage
    if (g == NSTAGE-1) begin : g_last
      sbox_dmr_stage #(.STG(g), .OW(8), .LAST(1'b1)) u_stage (
        .clk(clk), .rst_n(rst_n), .en(en), .vin(sv[g]), .din(sd[g]),
        .mask_a(mask_a[g]), .mask_b(mask_b[g]),
        .vout(out_valid), .dout(out_data), .err(err_flags[g])
      );
    end else begin : g_mid
      sbox_dmr_stage #(.STG(g), .OW(SW), .LAST(1'b0)) u_stage (
        .clk(clk), .rst_n(rst_n), .en(en), .vin(sv[g]), .din(sd[g]),
        .mask_a(mask_a[g]), .mask_b(mask_b[g]),
        .vout(sv[g+1]), .dout(sd[g+1]), .err(err_flags[g])
      );
    end
  end
endmodule

// File: rtl/sbox_dmr_chk.sv
module sbox_dmr_chk
  import sbox_tower_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              in_ready,
  input logic              out_valid,
  input logic [7:0]        out_data,
  input logic [NSTAGE-1:0] err_flags
);
  // R4
  stall_on_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|err_flags) |-> !in_ready);

  // R2
  ready_when_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(|err_flags) |-> in_ready);

  // R4
  no_out_after_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|err_flags) |=> !out_valid);

  // R8
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|err_flags) |=> $stable(out_data));

  // R3
  one_stage_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(err_flags));

  // R7
  always @(posedge clk) begin
    if (!rst_n) begin
      reset_clear_chk: assert (!out_valid && err_flags == '0);
    end
  end
endmodule

bind sbox_dmr_pipe sbox_dmr_chk i_chk (
  .clk(clk), .rst_n(rst_n), .in_ready(in_ready), .out_valid(out_valid),
  .out_data(out_data), .err_flags(err_flags)
);

// File: tb/test_sbox_dmr_pipe.sv
`timescale 1ns/1ps
module test_sbox_dmr_pipe;
  import sbox_tower_pkg::*;

  logic              clk;
  logic              rst_n;
  logic              in_valid;
  logic [7:0]        in_data;
  logic              in_ready;
  logic              out_valid;
  logic [7:0]        out_data;
  logic [NSTAGE-1:0] err_flags;
  logic              inj_start;
  logic [STG_W-1:0]  inj_stage;
  logic              inj_copy;
  logic [BIT_W-1:0]  inj_bit;
  logic [7:0]        inj_len;

  sbox_dmr_pipe i_sbox_dmr_pipe (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .in_ready(in_ready), .out_valid(out_valid), .out_data(out_data),
    .err_flags(err_flags), .inj_start(inj_start), .inj_stage(inj_stage),
    .inj_copy(inj_copy), .inj_bit(inj_bit), .inj_len(inj_len)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  logic [7:0] sref [256];
  logic [7:0] exp_q [$];
  logic [7:0] mon_exp;
  int n_chk = 0;
  int n_bad = 0;
  int stalls = 0;

  function automatic logic [7:0] aes_mul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] p, x;
    p = 8'h00;
    x = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) p = p ^ x;
      x = x[7] ? ((x << 1) ^ 8'h1B) : (x << 1);
    end
    return p;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, expv);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  // driver: called at a negedge, returns at the negedge after acceptance
  task automatic send(input logic [7:0] b);
    in_valid = 1'b1;
    in_data  = b;
    #1;
    while (!in_ready) begin
      stalls++;
      @(negedge clk);
      #1;
    end
    exp_q.push_back(sref[b]);
    @(posedge clk);
    @(negedge clk);
    inj_start = 1'b0;
  endtask

  task automatic drain();
    for (int k = 0; k < 80; k++)
      if (exp_q.size() != 0) @(negedge clk);
    check(exp_q.size() == 0, "R5 all accepted bytes emerged", exp_q.size(), 0);
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R5 output with nothing pending", out_data, 0);
      end else begin
        mon_exp = exp_q.pop_front();
        check(out_data == mon_exp, "R1 substituted byte", out_data, mon_exp);
      end
    end
  end

  initial begin
    #1_500_000;
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    logic [7:0] inv;
    int st0;
    int len;
    for (int x = 0; x < 256; x++) begin
      inv = 8'h00;
      for (int y = 1; y < 256; y++)
        if (aes_mul(8'(x), 8'(y)) == 8'h01) inv = 8'(y);
      sref[x] = inv ^ {inv[6:0], inv[7]} ^ {inv[5:0], inv[7:6]} ^
                {inv[4:0], inv[7:5]} ^ {inv[3:0], inv[7:4]} ^ 8'h63;
    end

    rst_n = 1'b1;
    in_valid = 1'b0;
    in_data = 8'h00;
    inj_start = 1'b0;
    inj_stage = '0;
    inj_copy = 1'b0;
    inj_bit = '0;
    inj_len = 8'd0;
    #2 rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check(!out_valid, "R7 out_valid low in reset", out_valid, 0);
    check(err_flags == '0, "R7 flags clear in reset", err_flags, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(in_ready, "R7 ready after reset", in_ready, 1);

    // R1 R2: full table, back to back
    st0 = stalls;
    for (int x = 0; x < 256; x++) send(8'(x));
    in_valid = 1'b0;
    check(stalls == st0, "R2 no stall without faults", stalls - st0, 0);
    drain();

    // R2 latency from idle
    send(8'h53);
    in_valid = 1'b0;
    for (int k = 1; k <= 4; k++) begin
      @(negedge clk);
      check(out_valid == (k == 4), "R2 latency", out_valid, (k == 4));
    end
    drain();

    // R3 R4 R5 R6: every stage and copy disturbed mid-stream
    for (int s = 0; s < NSTAGE; s++) begin
      for (int c = 0; c < 2; c++) begin
        len = 1 + ((s * 2 + c * 3) % 6);
        if (s == 2 && c == 1) len = 40;
        st0 = stalls;
        for (int i = 0; i < 12; i++) begin
          if (i == 6) begin
            inj_stage = STG_W'(s);
            inj_copy  = c[0];
            inj_bit   = BIT_W'((s + c * 4) % 8);
            inj_len   = 8'(len);
            inj_start = 1'b1;
          end
          send(8'(s * 53 + c * 101 + i * 29 + 7));
          if (i == 6) begin
            check(err_flags == (NSTAGE'(1) << s), "R3 flag of disturbed stage",
                  err_flags, 1 << s);
            check(!in_ready, "R4 ready low while flagged", in_ready, 0);
          end
        end
        in_valid = 1'b0;
        check(stalls - st0 == len, "R5 R6 stall length equals fault length",
              stalls - st0, len);
        drain();
      end
    end

    // R3: disturbing an idle stage raises nothing
    inj_stage = STG_W'(3);
    inj_copy  = 1'b0;
    inj_bit   = BIT_W'(2);
    inj_len   = 8'd6;
    inj_start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    inj_start = 1'b0;
    for (int k = 0; k < 6; k++) begin
      check(err_flags == '0 && in_ready, "R3 idle stage not flagged", err_flags, 0);
      @(negedge clk);
    end

    // R7: reset during a long fault
    for (int i = 0; i < 5; i++) begin
      if (i == 4) begin
        inj_stage = STG_W'(1);
        inj_copy  = 1'b1;
        inj_bit   = BIT_W'(5);
        inj_len   = 8'd30;
        inj_start = 1'b1;
      end
      send(8'(i * 17 + 3));
    end
    in_valid = 1'b0;
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check(!out_valid, "R7 out_valid cleared by reset", out_valid, 0);
    check(err_flags == '0, "R7 flags cleared by reset", err_flags, 0);
    exp_q.delete();
    rst_n = 1'b1;
    @(negedge clk);
    check(in_ready, "R7 ready after mid-fault reset", in_ready, 1);
    st0 = stalls;
    for (int i = 0; i < 4; i++) send(8'(i * 61 + 9));
    in_valid = 1'b0;
    check(stalls == st0, "R7 injection cancelled by reset", stalls - st0, 0);
    drain();

    summary();
    $finish;
  end
endmodule